// File: doc/BRIEF.md
# XON/XOFF In-Band Flow Control Engine

This block carries out software flow control for a serial port. On the receive side it looks at every character the receiver delivers. When a character equals one of the programmed stop characters, it closes a transmit gate. When a character equals one of the programmed resume characters, it opens the gate again. The gate tells the transmitter whether it may start a new character. A character already in flight is never cut short, so transmission stops only once that character has finished.

On the transmit side the block watches the receive FIFO fill level. When the level reaches the upper threshold, it asks the transmitter to insert a stop character. When the level later falls below the lower threshold, it asks for a resume character. Each request is held until the transmitter accepts it. The transmitter serves the request ahead of its next data character, even while the gate is closed.

Two 2-bit mode fields select which character pair is used by each side. A master enhanced-mode enable must be set for any of this to act. A 9-bit mode input switches the block off in both directions.

Top module: `xfc_engine`

## Requirements
- R1: After reset, `tx_enable` is 1 and `ins_req` is 0.
- R2: The receive mode field `rx_mode` selects the character pair used for matching. 2'b10 uses pair 1 only (`xon1`/`xoff1`). 2'b01 uses pair 2 only (`xon2`/`xoff2`). 2'b11 accepts either pair. A match requires all 8 bits to be equal, and it counts only in a cycle where `rx_valid` is 1. A stop-character match drives `tx_enable` to 0 from the clock edge that samples the strobe onward. A later resume-character match drives it back to 1 at the edge that samples that strobe.
- R3: Receive flow control is disabled when `rx_mode` is 2'b00. It is also disabled when `rx_mode` is 2'b11 while `tx_mode` is neither 2'b01 nor 2'b10. While disabled, the gate is forced open (`tx_enable` = 1) from the next edge, and received characters have no effect.
- R4: A received character that matches both an enabled stop character and an enabled resume character closes the gate.
- R5: While transmit insertion is active and no request is pending, a FIFO level at or above `thr_hi` raises `ins_req` with the stop character at the next edge. The request stays up until an edge samples `ins_ack` = 1. No further stop request is made until an edge sees the level below `thr_lo`. That edge raises `ins_req` with the resume character, and this request is also held until `ins_ack`.
- R6: The transmit mode field `tx_mode` selects the inserted pair. 2'b10 inserts `xon1`/`xoff1`, and 2'b01 inserts `xon2`/`xoff2`. The values 2'b00 and the reserved 2'b11 disable insertion, so `ins_req` stays 0.
- R7: While `enh_en` is 0, both sides are inactive: from the next edge `tx_enable` is 1 and `ins_req` is 0, whatever the other mode inputs are.
- R8: While `nine_bit` is 1, both sides are inactive in the same way as in R7.
- R9: Insertion requests are raised independently of the gate state. A threshold crossing while `tx_enable` is 0 still raises `ins_req`.
- R10: If insertion becomes inactive while a request is pending, the request is withdrawn at the next edge and the threshold tracking restarts from the below-threshold state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enh_en | input | 1 | Master enable for in-band flow control |
| nine_bit | input | 1 | 9-bit character mode; disables the block |
| rx_mode | input | 2 | Receive-side pair select (see R2, R3) |
| tx_mode | input | 2 | Transmit-side pair select (see R6) |
| xon1 | input | CHAR_W | Resume character, pair 1 |
| xon2 | input | CHAR_W | Resume character, pair 2 |
| xoff1 | input | CHAR_W | Stop character, pair 1 |
| xoff2 | input | CHAR_W | Stop character, pair 2 |
| rx_valid | input | 1 | Strobe: a received character is on `rx_data` |
| rx_data | input | CHAR_W | Received character |
| fifo_level | input | LVL_W | Receive FIFO fill level |
| thr_hi | input | LVL_W | Upper threshold (stop insertion) |
| thr_lo | input | LVL_W | Lower threshold (resume insertion) |
| ins_ack | input | 1 | Transmitter takes the pending inserted character |
| tx_enable | output | 1 | 1: the transmitter may start a new character |
| ins_req | output | 1 | Insertion request pending |
| ins_char | output | CHAR_W | Character to insert while `ins_req` is 1 |

Gate states: GATE_OPEN moves to GATE_PAUSED on a stop match. GATE_PAUSED moves to GATE_OPEN on a resume match or when receive control is disabled. Insert states: INS_BELOW moves to INS_REQ_XOFF when the level reaches `thr_hi`. INS_REQ_XOFF moves to INS_ABOVE on `ins_ack`. INS_ABOVE moves to INS_REQ_XON when the level drops below `thr_lo`. INS_REQ_XON moves to INS_BELOW on `ins_ack`. Every insert state returns to INS_BELOW when insertion is inactive.

## Verification
The gate update and the insertion state change can both happen on the same edge. In that case a stop or resume character arrives while the FIFO level crosses a threshold or while `ins_ack` retires a pending request. The random phase drives received characters, level walks across both thresholds and acknowledges in every cycle at once, so such collisions occur often. A directed case closes the gate and then crosses the upper threshold. On every cycle, the bench compares each output against its own model of the two sides, and each side is judged separately. A gate error therefore cannot hide behind a correct insertion result, and an insertion error cannot hide behind a correct gate.

// File: rtl/xfc_pkg.sv
package xfc_pkg;

    typedef enum logic {
        GATE_OPEN   = 1'b0,
        GATE_PAUSED = 1'b1
    } gate_state_e;

    typedef enum logic [1:0] {
        INS_BELOW    = 2'd0,
        INS_REQ_XOFF = 2'd1,
        INS_ABOVE    = 2'd2,
        INS_REQ_XON  = 2'd3
    } ins_state_e;

    localparam logic [1:0] MODE_OFF   = 2'b00;
    localparam logic [1:0] MODE_PAIR2 = 2'b01;
    localparam logic [1:0] MODE_PAIR1 = 2'b10;
    localparam logic [1:0] MODE_BOTH  = 2'b11;

endpackage

// File: rtl/xfc_mode_dec.sv
module xfc_mode_dec
    import xfc_pkg::*;
(
    input  logic       enh_en,
    input  logic       nine_bit,
    input  logic [1:0] rx_mode,
    input  logic [1:0] tx_mode,
    output logic       rx_act,
    output logic       rx_pair1,
    output logic       rx_pair2,
    output logic       tx_act,
    output logic       tx_pair1
);

    logic base_on;
    logic tx_ok;

    always_comb begin
        base_on  = enh_en && !nine_bit;
        tx_ok    = (tx_mode == MODE_PAIR2) || (tx_mode == MODE_PAIR1);
        rx_pair1 = 1'b0;
        rx_pair2 = 1'b0;
        unique case (rx_mode)
            MODE_OFF:   ;
            MODE_PAIR2: rx_pair2 = 1'b1;
            MODE_PAIR1: rx_pair1 = 1'b1;
            MODE_BOTH: begin
                rx_pair1 = 1'b1;
                rx_pair2 = 1'b1;
            end
        endcase
        // both-pair receive matching is only legal alongside a live transmit mode
        rx_act   = base_on && (rx_mode != MODE_OFF) &&
                   !((rx_mode == MODE_BOTH) && !tx_ok);
        tx_act   = base_on && tx_ok;
        tx_pair1 = (tx_mode == MODE_PAIR1);
    end

endmodule

// File: rtl/xfc_rx_gate.sv
module xfc_rx_gate
    import xfc_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_act,
    input  logic              rx_pair1,
    input  logic              rx_pair2,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic [CHAR_W-1:0] xon1,
    input  logic [CHAR_W-1:0] xon2,
    input  logic [CHAR_W-1:0] xoff1,
    input  logic [CHAR_W-1:0] xoff2,
    output logic              tx_enable
);

    gate_state_e state_q;
    gate_state_e state_d;
    logic        hit_stop;
    logic        hit_go;

    always_comb begin
        hit_stop = rx_valid && ((rx_pair1 && (rx_data == xoff1)) ||
                                (rx_pair2 && (rx_data == xoff2)));
        hit_go   = rx_valid && ((rx_pair1 && (rx_data == xon1)) ||
                                (rx_pair2 && (rx_data == xon2)));
    end

    always_comb begin
        state_d = state_q;
        if (!rx_act) begin
            state_d = GATE_OPEN;
        end else begin
            unique case (state_q)
                GATE_OPEN:   if (hit_stop) state_d = GATE_PAUSED;
                GATE_PAUSED: if (hit_go && !hit_stop) state_d = GATE_OPEN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            GATE_OPEN:   tx_enable = 1'b1;
            GATE_PAUSED: tx_enable = 1'b0;
        endcase
    end

endmodule

// File: rtl/xfc_tx_insert.sv
module xfc_tx_insert
    import xfc_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int LVL_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_act,
    input  logic              tx_pair1,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic [LVL_W-1:0]  thr_hi,
    input  logic [LVL_W-1:0]  thr_lo,
    input  logic              ins_ack,
    input  logic [CHAR_W-1:0] xon1,
    input  logic [CHAR_W-1:0] xon2,
    input  logic [CHAR_W-1:0] xoff1,
    input  logic [CHAR_W-1:0] xoff2,
    output logic              ins_req,
    output logic [CHAR_W-1:0] ins_char
);

    ins_state_e state_q;
    ins_state_e state_d;
    logic       at_top;
    logic       under_low;

    always_comb begin
        at_top    = fifo_level >= thr_hi;
        under_low = fifo_level <  thr_lo;
    end

    always_comb begin
        state_d = state_q;
        if (!tx_act) begin
            state_d = INS_BELOW;
        end else begin
            unique case (state_q)
                INS_BELOW:    if (at_top)    state_d = INS_REQ_XOFF;
                INS_REQ_XOFF: if (ins_ack)   state_d = INS_ABOVE;
                INS_ABOVE:    if (under_low) state_d = INS_REQ_XON;
                INS_REQ_XON:  if (ins_ack)   state_d = INS_BELOW;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= INS_BELOW;
        else        state_q <= state_d;
    end

    always_comb begin
        ins_req  = 1'b0;
        ins_char = '0;
        unique case (state_q)
            INS_BELOW, INS_ABOVE: ;
            INS_REQ_XOFF: begin
                ins_req  = 1'b1;
                ins_char = tx_pair1 ? xoff1 : xoff2;
            end
            INS_REQ_XON: begin
                ins_req  = 1'b1;
                ins_char = tx_pair1 ? xon1 : xon2;
            end
        endcase
    end

endmodule

// File: rtl/xfc_engine.sv
module xfc_engine
    import xfc_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int LVL_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enh_en,
    input  logic              nine_bit,
    input  logic [1:0]        rx_mode,
    input  logic [1:0]        tx_mode,
    input  logic [CHAR_W-1:0] xon1,
    input  logic [CHAR_W-1:0] xon2,
    input  logic [CHAR_W-1:0] xoff1,
    input  logic [CHAR_W-1:0] xoff2,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic [LVL_W-1:0]  thr_hi,
    input  logic [LVL_W-1:0]  thr_lo,
    input  logic              ins_ack,
    output logic              tx_enable,
    output logic              ins_req,
    output logic [CHAR_W-1:0] ins_char
);

    logic rx_act;
    logic rx_pair1;
    logic rx_pair2;
    logic tx_act;
    logic tx_pair1;

    xfc_mode_dec mode_i (
        .enh_en   (enh_en),
        .nine_bit (nine_bit),
        .rx_mode  (rx_mode),
        .tx_mode  (tx_mode),
        .rx_act   (rx_act),
        .rx_pair1 (rx_pair1),
        .rx_pair2 (rx_pair2),
        .tx_act   (tx_act),
        .tx_pair1 (tx_pair1)
    );

    xfc_rx_gate #(.CHAR_W(CHAR_W)) gate_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_act    (rx_act),
        .rx_pair1  (rx_pair1),
        .rx_pair2  (rx_pair2),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .xon1      (xon1),
        .xon2      (xon2),
        .xoff1     (xoff1),
        .xoff2     (xoff2),
        .tx_enable (tx_enable)
    );

    xfc_tx_insert #(.CHAR_W(CHAR_W), .LVL_W(LVL_W)) ins_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_act     (tx_act),
        .tx_pair1   (tx_pair1),
        .fifo_level (fifo_level),
        .thr_hi     (thr_hi),
        .thr_lo     (thr_lo),
        .ins_ack    (ins_ack),
        .xon1       (xon1),
        .xon2       (xon2),
        .xoff1      (xoff1),
        .xoff2      (xoff2),
        .ins_req    (ins_req),
        .ins_char   (ins_char)
    );

endmodule

// File: rtl/xfc_engine_chk.sv
module xfc_engine_chk #(
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enh_en,
    input logic              nine_bit,
    input logic [1:0]        rx_mode,
    input logic [1:0]        tx_mode,
    input logic [CHAR_W-1:0] xon1,
    input logic [CHAR_W-1:0] xoff1,
    input logic              rx_valid,
    input logic [CHAR_W-1:0] rx_data,
    input logic              ins_ack,
    input logic              tx_enable,
    input logic              ins_req
);

    assert_xoff1_pause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enh_en && !nine_bit && rx_mode == 2'b10 && rx_valid && rx_data == xoff1)
        |=> !tx_enable);

    assert_xon1_resume_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enh_en && !nine_bit && rx_mode == 2'b10 && rx_valid &&
         rx_data == xon1 && rx_data != xoff1)
        |=> tx_enable);

    assert_both_needs_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_mode == 2'b11 && (tx_mode == 2'b00 || tx_mode == 2'b11))
        |=> tx_enable);

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_req && !ins_ack && enh_en && !nine_bit &&
         (tx_mode == 2'b01 || tx_mode == 2'b10))
        |=> ins_req);

    assert_reserved_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mode == 2'b11) |=> !ins_req);

    assert_enh_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !enh_en |=> (tx_enable && !ins_req));

    assert_nine_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        nine_bit |=> (tx_enable && !ins_req));

endmodule

bind xfc_engine xfc_engine_chk #(.CHAR_W(CHAR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enh_en    (enh_en),
    .nine_bit  (nine_bit),
    .rx_mode   (rx_mode),
    .tx_mode   (tx_mode),
    .xon1      (xon1),
    .xoff1     (xoff1),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .ins_ack   (ins_ack),
    .tx_enable (tx_enable),
    .ins_req   (ins_req)
);

// File: tb/xfc_engine_tb_top.sv
`timescale 1ns/1ps
module xfc_engine_tb_top;

    localparam int CW = 8;
    localparam int LW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enh_en = 1'b0;
    logic          nine_bit = 1'b0;
    logic [1:0]    rx_mode = 2'b00;
    logic [1:0]    tx_mode = 2'b00;
    logic [CW-1:0] xon1 = 8'h11, xon2 = 8'h12, xoff1 = 8'h13, xoff2 = 8'h14;
    logic          rx_valid = 1'b0;
    logic [CW-1:0] rx_data = '0;
    logic [LW-1:0] fifo_level = '0;
    logic [LW-1:0] thr_hi = 7'd96;
    logic [LW-1:0] thr_lo = 7'd32;
    logic          ins_ack = 1'b0;
    logic          tx_enable;
    logic          ins_req;
    logic [CW-1:0] ins_char;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 0;
    string gate_tag = "R1";
    string ins_tag = "R1";

    // bench model state
    bit m_paused = 0;
    int m_ins = 0;   // 0 below, 1 stop pending, 2 above, 3 resume pending

    always #10 clk = ~clk;

    xfc_engine #(.CHAR_W(CW), .LVL_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .enh_en(enh_en), .nine_bit(nine_bit),
        .rx_mode(rx_mode), .tx_mode(tx_mode), .xon1(xon1), .xon2(xon2),
        .xoff1(xoff1), .xoff2(xoff2), .rx_valid(rx_valid), .rx_data(rx_data),
        .fifo_level(fifo_level), .thr_hi(thr_hi), .thr_lo(thr_lo),
        .ins_ack(ins_ack), .tx_enable(tx_enable), .ins_req(ins_req),
        .ins_char(ins_char)
    );

    function automatic bit tx_mode_ok();
        return (tx_mode == 2'b01) || (tx_mode == 2'b10);
    endfunction

    function automatic bit exp_rx_on();
        return enh_en && !nine_bit && rx_mode != 2'b00 &&
               !(rx_mode == 2'b11 && !tx_mode_ok());
    endfunction

    function automatic bit exp_tx_on();
        return enh_en && !nine_bit && tx_mode_ok();
    endfunction

    function automatic logic [CW-1:0] exp_char(int st);
        if (st == 1) return (tx_mode == 2'b10) ? xoff1 : xoff2;
        return (tx_mode == 2'b10) ? xon1 : xon2;
    endfunction

    task automatic model_edge();
        bit stop_hit, go_hit;
        if (!exp_rx_on()) begin
            m_paused = 0;
        end else if (rx_valid) begin
            stop_hit = (rx_mode[1] && rx_data == xoff1) || (rx_mode[0] && rx_data == xoff2);
            go_hit   = (rx_mode[1] && rx_data == xon1)  || (rx_mode[0] && rx_data == xon2);
            if (stop_hit)     m_paused = 1;
            else if (go_hit)  m_paused = 0;
        end
        if (!exp_tx_on()) m_ins = 0;
        else case (m_ins)
            0: if (fifo_level >= thr_hi) m_ins = 1;
            1: if (ins_ack) m_ins = 2;
            2: if (fifo_level < thr_lo) m_ins = 3;
            default: if (ins_ack) m_ins = 0;
        endcase
    endtask

    task automatic check(string tag, string what, logic [CW-1:0] got, logic [CW-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic check_all();
        bit exp_req;
        exp_req = (m_ins == 1) || (m_ins == 3);
        check(gate_tag, "tx_enable", {7'd0, tx_enable}, {7'd0, !m_paused});
        check(ins_tag, "ins_req", {7'd0, ins_req}, {7'd0, exp_req});
        if (exp_req && ins_req) check(ins_tag, "ins_char", ins_char, exp_char(m_ins));
    endtask

    // inputs were set after a falling edge; evaluate one rising edge and sample at the next fall
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_all();
    endtask

    task automatic rx_char(logic [CW-1:0] c);
        rx_valid = 1'b1;
        rx_data  = c;
        step();
        rx_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        gate_tag = "R1"; ins_tag = "R1";
        check_all();
        rst_n = 1'b1;
        @(negedge clk);
        check_all();

        // R2: pair 1 only
        enh_en = 1; rx_mode = 2'b10; tx_mode = 2'b10; gate_tag = "R2"; ins_tag = "R2";
        rx_char(xoff2);
        rx_char(xoff1 ^ 8'h80);
        rx_valid = 1'b0; rx_data = xoff1; step();
        rx_char(xoff1);
        rx_char(xon2);
        rx_char(xon1);
        // pair 2 only
        rx_mode = 2'b01;
        rx_char(xoff1);
        rx_char(xoff2);
        rx_char(xon1);
        rx_char(xon2);
        // both pairs with a live transmit mode
        rx_mode = 2'b11; tx_mode = 2'b01;
        rx_char(xoff1);
        rx_char(xon2);
        rx_char(xoff2);
        rx_char(xon1);

        // R3: both pairs without a live transmit mode, and mode off
        gate_tag = "R3"; ins_tag = "R3";
        rx_mode = 2'b11; tx_mode = 2'b00;
        rx_char(xoff1);
        tx_mode = 2'b11;
        rx_char(xoff2);
        rx_mode = 2'b10; tx_mode = 2'b10;
        rx_char(xoff1);
        rx_mode = 2'b00;
        step();
        rx_char(xoff1);

        // R4: a character that is both a resume and a stop character
        gate_tag = "R4";
        rx_mode = 2'b11; tx_mode = 2'b10; xon1 = xoff2;
        rx_char(xoff2);
        rx_char(xon2);
        xon1 = 8'h11;
        rx_char(xon1);

        // R7: master enable off
        gate_tag = "R7"; ins_tag = "R7";
        rx_char(xoff1);
        enh_en = 0; fifo_level = 7'd120;
        step();
        rx_char(xoff1);
        step();
        enh_en = 1; fifo_level = 7'd0; step();

        // R8: 9-bit mode
        gate_tag = "R8"; ins_tag = "R8";
        rx_char(xoff1);
        nine_bit = 1; fifo_level = 7'd120;
        step();
        rx_char(xoff1);
        nine_bit = 0; fifo_level = 7'd0; rx_char(xon1);

        // R5: threshold crossings, pair 1 insertion
        gate_tag = "R5"; ins_tag = "R5";
        tx_mode = 2'b10; rx_mode = 2'b10;
        fifo_level = 7'd95; step();
        fifo_level = 7'd96; step();
        step(); step();
        ins_ack = 1; step(); ins_ack = 0;
        step(); step();
        fifo_level = 7'd32; step();
        fifo_level = 7'd31; step();
        step();
        ins_ack = 1; step(); ins_ack = 0;
        step();

        // R6: pair 2 insertion and reserved mode
        ins_tag = "R6";
        tx_mode = 2'b01; rx_mode = 2'b01;
        fifo_level = 7'd100; step();
        ins_ack = 1; step(); ins_ack = 0;
        fifo_level = 7'd5; step();
        ins_ack = 1; step(); ins_ack = 0;
        tx_mode = 2'b11; rx_mode = 2'b10; fifo_level = 7'd110;
        step(); step();
        fifo_level = 7'd0; step();

        // R9: request raised while the gate is closed
        gate_tag = "R9"; ins_tag = "R9";
        tx_mode = 2'b10;
        rx_char(xoff1);
        fifo_level = 7'd100; rx_char(xoff1);
        step();
        ins_ack = 1; step(); ins_ack = 0;
        fifo_level = 7'd0; rx_char(xon1);
        ins_ack = 1; step(); ins_ack = 0;

        // R10: withdrawal of a pending request
        ins_tag = "R10"; gate_tag = "R10";
        fifo_level = 7'd100; step();
        tx_mode = 2'b00; step();
        tx_mode = 2'b10; step();
        step();
        ins_ack = 1; fifo_level = 7'd0; step(); ins_ack = 0;
        step();
        ins_ack = 1; step(); ins_ack = 0;

        // random phase: characters, level walks and acks all at once
        gate_tag = "R2"; ins_tag = "R5";
        for (int i = 0; i < 4000; i++) begin
            int pick;
            int lv;
            if ($urandom % 50 == 0) rx_mode = 2'($urandom);
            if ($urandom % 50 == 0) tx_mode = 2'($urandom);
            enh_en   = ($urandom % 40) != 0;
            nine_bit = ($urandom % 60) == 0;
            if ($urandom % 300 == 0) begin
                thr_hi = 7'(64 + $urandom % 60);
                thr_lo = 7'(4 + $urandom % 50);
            end
            pick = $urandom % 6;
            rx_valid = ($urandom % 3) == 0;
            case (pick)
                0: rx_data = xon1;
                1: rx_data = xon2;
                2: rx_data = xoff1;
                3: rx_data = xoff2;
                default: rx_data = 8'($urandom);
            endcase
            lv = int'(fifo_level) + int'($urandom % 17) - 8;
            if (lv < 0) lv = 0;
            if (lv > 127) lv = 127;
            fifo_level = 7'(lv);
            ins_ack = ($urandom % 4) == 0;
            step();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule